// File: doc/BRIEF.md
# Diagnostic Clock Output Selector with Divider Bypass

This block drives one diagnostic pin of a clock synthesizer and owns the divider chain that the pin observes. A 3-bit select code picks what appears on the pin. It can show the serial configuration register's outgoing bit, a fixed high or low level, the reference divided by sixteen, the pulses of the feedback counter, the synthesized main output, or that main output divided by four. Another code puts the block into bypass. In bypass the slow serial clock takes the place of the oscillator clock, drives both the feedback counter and the post-divider, and the pin shows the counter's pulses. Bypass lets board-level tests step the clock tree by hand.

All logic runs on one fabric clock. Each source clock (reference, oscillator, serial) arrives as a one-cycle strobe, which marks one edge of that source. A small switch chooses which strobe stream feeds the dividers. It breaks the old source before it makes the new one and keeps both off for a settle gap, so no divider ever sees a merged or partial edge.

Top module: `test_out_sel`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `fout_o` and `test_o` are 0 and the oscillator strobe is the active divider source.
- R2: Select code 3'b001 drives `test_o` to 1, code 3'b101 drives it to 0, and code 3'b000 copies `sr_bit`. Each takes effect one cycle after the code and data are sampled.
- R3: With code 3'b010, `test_o` changes level once for every 16 reference strobes.
- R4: `fout_o` changes level once for every 1, 2, 4 or 8 active-source strobes when `n_code` is 00, 01, 10 or 11 respectively.
- R5: The 9-bit feedback counter emits a one-cycle pulse once per `m_ratio` active-source strobes, for any value from 1 to 511. When `m_ratio` is 0 it emits no pulse. Code 3'b011 routes these pulses to `test_o`.
- R6: Code 3'b100 shows `fout_o` on `test_o`. Code 3'b111 shows a signal that changes level once for every four level changes of `fout_o`.
- R7: Code 3'b110 (bypass) feeds both dividers from `ser_tick`, ignores `vco_tick`, and shows the feedback pulses on `test_o`.
- R8: Under any code other than 3'b110, `ser_tick` has no effect on either divider.
- R9: At most one source is enabled at any time. A newly enabled source is enabled only after both sources have been off for two cycles. After leaving bypass the oscillator again drives the dividers.
- R10: `test_o` is a registered output and changes only on the fabric clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe per reference edge |
| vco_tick | input | 1 | One-cycle strobe per oscillator edge |
| ser_tick | input | 1 | One-cycle strobe per serial clock edge |
| sr_bit | input | 1 | Outgoing bit of the serial configuration register |
| m_ratio | input | 9 | Feedback counter ratio, 0 to 511 |
| n_code | input | 2 | Post-divider code: 00 gives /1, 01 gives /2, 10 gives /4, 11 gives /8 |
| tsel | input | 3 | Diagnostic select code |
| fout_o | output | 1 | Main divided output level |
| test_o | output | 1 | Diagnostic pin |

## Verification
On every cycle the assertions check that the source enables are never both on, that a new source waits two dead cycles, and that each divider and the prescaler change level only after an enabled strobe. They also check that a zero ratio keeps the counter silent and that the constant and pass-through codes reach the pin one cycle later. Only the bench's scenarios can show the actual division ratios. These are the level-change counts over a long run of strobes at each post-divider code, the 511 ratio, the divide-by-sixteen and divide-by-four paths, and whether the strobe from the source that is not selected is really ignored. The bench also shows that the dividers resume on the oscillator after a round trip through bypass.

// File: rtl/tos_pkg.sv
package tos_pkg;

    typedef enum logic [2:0] {
        TS_SHIFT  = 3'b000,
        TS_ONE    = 3'b001,
        TS_REF16  = 3'b010,
        TS_FBK    = 3'b011,
        TS_MAIN   = 3'b100,
        TS_ZERO   = 3'b101,
        TS_BYPASS = 3'b110,
        TS_MAIN_Q = 3'b111
    } tsel_e;

    typedef enum logic [1:0] {
        SRC_PLL = 2'd0,
        SRC_GAP = 2'd1,
        SRC_SER = 2'd2
    } src_state_e;

    typedef struct packed {
        logic ref16;
        logic fbk_pulse;
        logic main_lvl;
        logic main_q;
    } div_taps_t;

    function automatic logic wants_serial(input tsel_e code);
        return code == TS_BYPASS;
    endfunction

endpackage

// File: rtl/tos_toggle_div.sv
module tos_toggle_div #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          q,
    output logic          flip
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            q    <= 1'b0;
            flip <= 1'b0;
        end else begin
            flip <= 1'b0;
            if (tick) begin
                if (cnt >= limit) begin
                    cnt  <= '0;
                    q    <= ~q;
                    flip <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R4 / R3: a level change always follows an accepted strobe
    p_flip_after_tick_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(q) |-> $past(tick));

endmodule

// File: rtl/tos_fb_counter.sv
module tos_fb_counter #(
    parameter int M_W = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic [M_W-1:0] m_ratio,
    output logic           pulse
);
    logic [M_W-1:0] cnt;
    logic [M_W-1:0] last;

    assign last = m_ratio - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (m_ratio == '0) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt >= last) begin
                    cnt   <= '0;
                    pulse <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R5: a zero ratio keeps the counter silent
    p_zero_ratio_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (m_ratio == '0) |=> !pulse);

    // R5: every pulse is caused by a strobe in the previous cycle
    p_pulse_needs_tick_r5: assert property (@(posedge clk) disable iff (rst)
        pulse |-> $past(tick));

endmodule

// File: rtl/tos_src_switch.sv
module tos_src_switch
    import tos_pkg::*;
#(
    parameter int SETTLE = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic want_ser,
    output logic en_pll,
    output logic en_ser
);
    localparam int GW = $clog2(SETTLE + 1);

    src_state_e    state;
    logic [GW-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SRC_PLL;
            gap   <= '0;
        end else begin
            case (state)
                SRC_PLL: if (want_ser) begin
                    state <= SRC_GAP;
                    gap   <= '0;
                end
                SRC_SER: if (!want_ser) begin
                    state <= SRC_GAP;
                    gap   <= '0;
                end
                SRC_GAP: begin
                    if (gap == GW'(SETTLE - 1))
                        state <= want_ser ? SRC_SER : SRC_PLL;
                    else
                        gap <= gap + 1'b1;
                end
                default: state <= SRC_PLL;
            endcase
        end
    end

    assign en_pll = (state == SRC_PLL);
    assign en_ser = (state == SRC_SER);

    // R9: never two sources at once
    p_one_source_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({en_pll, en_ser}));

    // R9: serial source only after two dead cycles
    p_ser_gap_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(en_ser) |-> (!$past(en_pll, 1) && !$past(en_pll, 2)));

    // R9: oscillator source only after two dead cycles
    p_pll_gap_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(en_pll) |-> (!$past(en_ser, 1) && !$past(en_ser, 2)));

endmodule

// File: rtl/test_out_sel.sv
module test_out_sel
    import tos_pkg::*;
#(
    parameter int M_W       = 9,
    parameter int PRE_RATIO = 16,
    parameter int N_W       = 2,
    parameter int QDIV      = 4,
    parameter int SETTLE    = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ref_tick,
    input  logic           vco_tick,
    input  logic           ser_tick,
    input  logic           sr_bit,
    input  logic [M_W-1:0] m_ratio,
    input  logic [N_W-1:0] n_code,
    input  logic [2:0]     tsel,
    output logic           fout_o,
    output logic           test_o
);
    localparam int PRE_CW  = $clog2(PRE_RATIO);
    localparam int POST_CW = (1 << N_W) - 1;
    localparam int Q_CW    = $clog2(QDIV);

    tsel_e     code;
    div_taps_t taps;
    logic      en_pll, en_ser, src_tick, main_flip, ref_flip, q_flip;
    logic [POST_CW-1:0] post_lim;

    assign code     = tsel_e'(tsel);
    assign src_tick = (en_pll & vco_tick) | (en_ser & ser_tick);
    assign post_lim = POST_CW'((1 << n_code) - 1);

    tos_src_switch #(.SETTLE(SETTLE)) u_switch (
        .clk      (clk),
        .rst      (rst),
        .want_ser (wants_serial(code)),
        .en_pll   (en_pll),
        .en_ser   (en_ser)
    );

    tos_toggle_div #(.CW(PRE_CW)) u_prescale (
        .clk   (clk),
        .rst   (rst),
        .tick  (ref_tick),
        .limit (PRE_CW'(PRE_RATIO - 1)),
        .q     (taps.ref16),
        .flip  (ref_flip)
    );

    tos_toggle_div #(.CW(POST_CW)) u_post (
        .clk   (clk),
        .rst   (rst),
        .tick  (src_tick),
        .limit (post_lim),
        .q     (taps.main_lvl),
        .flip  (main_flip)
    );

    tos_toggle_div #(.CW(Q_CW)) u_quarter (
        .clk   (clk),
        .rst   (rst),
        .tick  (main_flip),
        .limit (Q_CW'(QDIV - 1)),
        .q     (taps.main_q),
        .flip  (q_flip)
    );

    tos_fb_counter #(.M_W(M_W)) u_fbk (
        .clk     (clk),
        .rst     (rst),
        .tick    (src_tick),
        .m_ratio (m_ratio),
        .pulse   (taps.fbk_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            test_o <= 1'b0;
        end else begin
            case (code)
                TS_SHIFT:  test_o <= sr_bit;
                TS_ONE:    test_o <= 1'b1;
                TS_REF16:  test_o <= taps.ref16;
                TS_FBK:    test_o <= taps.fbk_pulse;
                TS_MAIN:   test_o <= taps.main_lvl;
                TS_ZERO:   test_o <= 1'b0;
                TS_BYPASS: test_o <= taps.fbk_pulse;
                TS_MAIN_Q: test_o <= taps.main_q;
                default:   test_o <= 1'b0;
            endcase
        end
    end

    assign fout_o = taps.main_lvl;

    // R2: constant-high code reaches the pin one cycle later
    p_const_one_r2: assert property (@(posedge clk) disable iff (rst)
        (tsel == 3'b001) |=> test_o);

    // R2: constant-low code reaches the pin one cycle later
    p_const_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (tsel == 3'b101) |=> !test_o);

    // R2 / R10: shift-register bit copied with one register of delay
    p_shift_copy_r2: assert property (@(posedge clk) disable iff (rst)
        (tsel == 3'b000) |=> (test_o == $past(sr_bit)));

    // R7 / R8: oscillator strobes never reach the dividers in bypass
    p_bypass_no_vco_r7: assert property (@(posedge clk) disable iff (rst)
        en_ser |-> !en_pll);

endmodule

// File: tb/tb_test_out_sel.sv
module tb_test_out_sel;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_tick = 1'b0, vco_tick = 1'b0, ser_tick = 1'b0, sr_bit = 1'b0;
    logic [8:0] m_ratio = 9'd1;
    logic [1:0] n_code = 2'd0;
    logic [2:0] tsel = 3'b100;
    logic       fout_o, test_o;

    int  n_chk = 0, n_err = 0;
    int  tc = 0, fc = 0;
    logic pt = 1'b0, pf = 1'b0, cnt_on = 1'b0, done = 1'b0;

    always #2 clk = ~clk;

    test_out_sel dut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .vco_tick(vco_tick),
        .ser_tick(ser_tick), .sr_bit(sr_bit), .m_ratio(m_ratio),
        .n_code(n_code), .tsel(tsel), .fout_o(fout_o), .test_o(test_o)
    );

    always @(negedge clk) begin
        if (cnt_on) begin
            if (test_o !== pt) tc++;
            if (fout_o !== pf) fc++;
        end
        pt = test_o;
        pf = fout_o;
    end

    // src: 0 reference, 1 oscillator, 2 serial
    typedef struct packed {
        logic [2:0] ts;
        logic [1:0] src;
        logic [8:0] m;
        logic [1:0] n;
        int         ticks;
        int         exp_t;
        int         exp_f;
        logic       lvl;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{3'b010, 2'd0, 9'd1,   2'd0, 64,   4,  0,    1'b0}, // R3 ref /16
        '{3'b011, 2'd1, 9'd5,   2'd0, 30,   12, 30,   1'b0}, // R5 ratio 5, R4 /1
        '{3'b100, 2'd1, 9'd1,   2'd2, 32,   8,  8,    1'b0}, // R6 main, R4 /4
        '{3'b111, 2'd1, 9'd1,   2'd1, 64,   8,  32,   1'b0}, // R6 quarter, R4 /2
        '{3'b110, 2'd2, 9'd3,   2'd3, 48,   32, 6,    1'b0}, // R7 bypass, R4 /8
        '{3'b110, 2'd1, 9'd1,   2'd0, 40,   0,  0,    1'b0}, // R7 oscillator ignored
        '{3'b011, 2'd2, 9'd1,   2'd0, 40,   0,  0,    1'b0}, // R8 serial ignored
        '{3'b011, 2'd1, 9'd0,   2'd0, 20,   0,  20,   1'b0}, // R5 ratio zero
        '{3'b001, 2'd1, 9'd1,   2'd0, 10,   0,  10,   1'b1}, // R2 constant one
        '{3'b100, 2'd1, 9'd1,   2'd0, 5,    5,  5,    1'b1}, // R6 odd count
        '{3'b011, 2'd1, 9'd511, 2'd0, 1022, 4,  1022, 1'b0}  // R5 ratio 511
    };

    function automatic string req_of(int i);
        case (i)
            0: return "R3";
            1, 7, 10: return "R5";
            2, 3, 9: return "R6";
            4, 5: return "R7";
            6: return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_src(input logic [1:0] src);
        @(negedge clk);
        case (src)
            2'd0: ref_tick = 1'b1;
            2'd1: vco_tick = 1'b1;
            default: ser_tick = 1'b1;
        endcase
        @(negedge clk);
        ref_tick = 1'b0; vco_tick = 1'b0; ser_tick = 1'b0;
    endtask

    task automatic start_count();
        @(negedge clk); #1;
        tc = 0; fc = 0; cnt_on = 1'b1;
    endtask

    task automatic stop_count();
        repeat (6) @(negedge clk);
        #1 cnt_on = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(test_o == 1'b0, "R1", "test_o in reset", test_o, 0);
        check(fout_o == 1'b0, "R1", "fout_o in reset", fout_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(fout_o == 1'b0 && test_o == 1'b0, "R1", "outputs after reset",
              {fout_o, test_o}, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk); rst = 1'b1;
            tsel = VEC[i].ts; m_ratio = VEC[i].m; n_code = VEC[i].n;
            repeat (3) @(negedge clk);
            rst = 1'b0;
            repeat (8) @(negedge clk);
            start_count();
            for (int k = 0; k < VEC[i].ticks; k++) pulse_src(VEC[i].src);
            stop_count();
            check(tc == VEC[i].exp_t, req_of(i), $sformatf("vec %0d test toggles", i),
                  tc, VEC[i].exp_t);
            check(fc == VEC[i].exp_f, req_of(i), $sformatf("vec %0d fout toggles", i),
                  fc, VEC[i].exp_f);
            check(test_o == VEC[i].lvl, req_of(i), $sformatf("vec %0d test level", i),
                  test_o, VEC[i].lvl);
        end

        // R2: shift-register pass-through and constant zero
        do_reset();
        tsel = 3'b000; sr_bit = 1'b1;
        @(negedge clk); @(negedge clk);
        check(test_o == 1'b1, "R2", "shift bit high", test_o, 1);
        sr_bit = 1'b0;
        @(negedge clk);
        check(test_o == 1'b0, "R2", "shift bit low", test_o, 0);
        tsel = 3'b001;
        @(negedge clk);
        check(test_o == 1'b1, "R10", "one cycle to constant high", test_o, 1);
        tsel = 3'b101;
        @(negedge clk);
        check(test_o == 1'b0, "R2", "constant low", test_o, 0);

        // R9: round trip through bypass, oscillator resumes
        do_reset();
        m_ratio = 9'd1; n_code = 2'd0; tsel = 3'b110;
        repeat (8) @(negedge clk);
        start_count();
        for (int k = 0; k < 6; k++) pulse_src(2'd2);
        stop_count();
        check(fc == 6, "R9", "serial drives post-divider", fc, 6);
        tsel = 3'b100;
        repeat (8) @(negedge clk);
        start_count();
        for (int k = 0; k < 8; k++) pulse_src(2'd1);
        stop_count();
        check(fc == 8, "R9", "oscillator resumes after bypass", fc, 8);
        start_count();
        for (int k = 0; k < 8; k++) pulse_src(2'd2);
        stop_count();
        check(fc == 0, "R8", "serial ignored after bypass", fc, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule